// File: doc/BRIEF.md
# Byte-Port Interrupt Mask Controller

This block gathers up to eight interrupt lines from peripherals into one level-sensitive request to an upstream chipset interrupt controller. Each peripheral raises its line by pulsing a bit on the set vector, and withdraws it by pulsing the matching bit on the withdraw vector. A pending register holds the raised lines. An enable register selects which of them may reach the request output.

Software reaches the block through a small byte-addressed port. It can program the enable register, read the pending lines and retire a single line by number. The enable port uses inverted polarity: a written 1 blocks the line. A second cascaded controller exists only as register stubs. It keeps a mask byte that software can read back, and its status always reads as zero. A 64-bit read is accepted only at the primary status address. Every access the block does not support raises an error flag in the same cycle and leaves all state unchanged.

Register offsets on `acc_addr_i`: 0 primary mask (read and write), 1 primary status (read only), 2 acknowledge (write only), 3 secondary mask (read and write), 4 secondary status (read; a write is ignored). Offsets 5 to 7 are unused.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is active and until the first accepted write, the pending register is 0x00, every line is disabled (a primary mask read returns 0xFF), the secondary mask reads 0x00 and `irq_o` is low.
- R2: A byte write to offset 0 stores the complement of the byte as the enable register, so a 1 bit blocks that line. A byte read of offset 0 returns the complement of the enable register, which is the last byte written.
- R3: After every clock edge, `irq_o` equals the OR over all bits of (pending AND enable) as updated at that edge. It therefore rises or falls one cycle after the mask write, set, withdraw or acknowledge that changed the result.
- R4: Every 1 bit on `set_vec_i` in a clock cycle sets the matching pending bit at that edge.
- R5: Every 1 bit on `clr_vec_i` clears the matching pending bit at that edge. When the same bit is both set and withdrawn in one cycle, the withdraw wins.
- R6: A byte write to offset 2 takes n from write-data bits [3:0] and ignores bits [7:4]. It clears pending bit n when n < 8, and it wins over a set of the same bit in the same cycle. When n is 8 to 15 nothing changes.
- R7: A byte read of offset 1 returns the pending register in `rd_data_o[7:0]`. The upper bits are zero.
- R8: A byte write to offset 3 stores the byte unmodified. A read of offset 3 returns that byte. This mask never affects `irq_o`.
- R9: A byte read of offset 4 returns 0x00. A byte write to offset 4 is accepted without error and changes nothing.
- R10: A wide (`acc_wide_i`=1) read of offset 1 returns the pending register zero-extended to 64 bits, with no error.
- R11: `acc_err_o` is high in the same cycle as any of these accesses, and the access then has no effect and returns zero data: a wide write, a wide read at any offset other than 1, a byte write to offset 1, a byte read of offset 2, or any access to offsets 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid_i | input | 1 | Register access strobe, one access per cycle |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_wide_i | input | 1 | 1 for a 64-bit access, 0 for a byte access |
| acc_addr_i | input | 3 | Register offset |
| acc_wdata_i | input | 8 | Write data byte |
| rd_data_o | output | 64 | Read data, combinational in the access cycle |
| acc_err_o | output | 1 | Unsupported access, combinational in the access cycle |
| set_vec_i | input | 8 | Peripheral set bitvector |
| clr_vec_i | input | 8 | Peripheral withdraw bitvector |
| irq_o | output | 1 | Level request to the upstream controller |

## Verification
A corrupted pending or enable bit shows on `irq_o` one cycle after the edge that stores it, provided the line is both pending and enabled. If it is not, the fault stays hidden until software reads offset 0 or offset 1, and the read data then shows it in the same cycle. A decode fault that lets an illegal access through does not always show on the error flag alone. It does show on the following cycle as a changed mask read or a changed request level. For that reason, the illegal writes in the bench carry data that would visibly change the state if they were wrongly accepted.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  typedef enum logic [2:0] {
    OFS_MASK_P = 3'd0,
    OFS_STAT_P = 3'd1,
    OFS_ACK_P  = 3'd2,
    OFS_MASK_S = 3'd3,
    OFS_STAT_S = 3'd4
  } reg_ofs_e;

  typedef struct packed {
    logic wr_mask_p;
    logic wr_mask_s;
    logic wr_ack;
    logic rd_mask_p;
    logic rd_stat_p;
    logic rd_mask_s;
    logic rd_stat_s;
    logic err;
  } acc_dec_t;

endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
  import irqm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_dec_t          dec_o
);

  logic hit_mask_p, hit_stat_p, hit_ack, hit_mask_s, hit_stat_s, known;
  logic bad;

  always_comb begin
    hit_mask_p = (addr_i == ADDR_W'(OFS_MASK_P));
    hit_stat_p = (addr_i == ADDR_W'(OFS_STAT_P));
    hit_ack    = (addr_i == ADDR_W'(OFS_ACK_P));
    hit_mask_s = (addr_i == ADDR_W'(OFS_MASK_S));
    hit_stat_s = (addr_i == ADDR_W'(OFS_STAT_S));
    known      = hit_mask_p | hit_stat_p | hit_ack | hit_mask_s | hit_stat_s;

    if (wide_i) bad = write_i | ~hit_stat_p;
    else        bad = ~known | (write_i & hit_stat_p) | (~write_i & hit_ack);

    dec_o.err       = valid_i & bad;
    dec_o.wr_mask_p = valid_i & ~bad & write_i & hit_mask_p;
    dec_o.wr_mask_s = valid_i & ~bad & write_i & hit_mask_s;
    dec_o.wr_ack    = valid_i & ~bad & write_i & hit_ack;
    dec_o.rd_mask_p = valid_i & ~bad & ~write_i & hit_mask_p;
    dec_o.rd_stat_p = valid_i & ~bad & ~write_i & hit_stat_p;
    dec_o.rd_mask_s = valid_i & ~bad & ~write_i & hit_mask_s;
    dec_o.rd_stat_s = valid_i & ~bad & ~write_i & hit_stat_s;
  end

endmodule

// File: rtl/irqm_pend.sv
module irqm_pend #(
  parameter int NL    = 8,
  parameter int ACK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NL-1:0]    set_i,
  input  logic [NL-1:0]    clr_i,
  input  logic             ack_we_i,
  input  logic [ACK_W-1:0] ack_num_i,
  output logic [NL-1:0]    pend_q,
  output logic [NL-1:0]    pend_nxt_o
);

  logic [NL-1:0] ack_hit;
  logic          upd_en;

  for (genvar i = 0; i < NL; i++) begin : g_ack
    assign ack_hit[i] = ack_we_i && (ack_num_i == ACK_W'(i));
  end

  always_comb begin
    upd_en     = (|set_i) | (|clr_i) | ack_we_i;
    pend_nxt_o = ((pend_q | set_i) & ~clr_i) & ~ack_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_nxt_o;
  end

  // R4
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_i) && !(|clr_i) && !ack_we_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R5
  clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((pend_q & $past(clr_i)) == '0));

  // R6
  ack_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we_i && (int'(ack_num_i) < NL)) |=> !pend_q[$past(ack_num_i)]);

endmodule

// File: rtl/irqm_masks.sv
module irqm_masks #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_p_i,
  input  logic          wr_s_i,
  input  logic [NL-1:0] wdata_i,
  output logic [NL-1:0] en_q,
  output logic [NL-1:0] en_nxt_o,
  output logic [NL-1:0] aux_q
);

  logic [NL-1:0] aux_d;

  always_comb begin
    en_nxt_o = wr_p_i ? ~wdata_i : en_q;
    aux_d    = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_p_i) en_q <= en_nxt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      aux_q <= '0;
    else if (wr_s_i) aux_q <= aux_d;
  end

  // R2
  mask_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_p_i |=> (en_q == ~$past(wdata_i)));

  // R8
  aux_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_s_i |=> $stable(aux_q));

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqm_pkg::*;
#(
  parameter int NL     = 8,
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 64,
  parameter int ACK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic              acc_wide_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [NL-1:0]     acc_wdata_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              acc_err_o,
  input  logic [NL-1:0]     set_vec_i,
  input  logic [NL-1:0]     clr_vec_i,
  output logic              irq_o
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_int_n;
  acc_dec_t          dec;
  logic [NL-1:0]     pend_q, pend_nxt, en_q, en_nxt, aux_q;
  logic              irq_d, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_N-1];

  irqm_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .wide_i  (acc_wide_i),
    .addr_i  (acc_addr_i),
    .dec_o   (dec)
  );

  irqm_pend #(.NL(NL), .ACK_W(ACK_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .set_i      (set_vec_i),
    .clr_i      (clr_vec_i),
    .ack_we_i   (dec.wr_ack),
    .ack_num_i  (acc_wdata_i[ACK_W-1:0]),
    .pend_q     (pend_q),
    .pend_nxt_o (pend_nxt)
  );

  irqm_masks #(.NL(NL)) u_masks (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_p_i   (dec.wr_mask_p),
    .wr_s_i   (dec.wr_mask_s),
    .wdata_i  (acc_wdata_i),
    .en_q     (en_q),
    .en_nxt_o (en_nxt),
    .aux_q    (aux_q)
  );

  always_comb irq_d = |(pend_nxt & en_nxt);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  always_comb begin
    rd_data_o = '0;
    unique case (1'b1)
      dec.rd_mask_p: rd_data_o[NL-1:0] = ~en_q;
      dec.rd_stat_p: rd_data_o[NL-1:0] = pend_q;
      dec.rd_mask_s: rd_data_o[NL-1:0] = aux_q;
      default:       rd_data_o = '0;
    endcase
    acc_err_o = dec.err;
  end

  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o == |(pend_q & en_q));

  // R9
  aux_stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    dec.rd_stat_s |-> (rd_data_o == '0));

  // R11
  wide_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid_i && acc_wide_i && acc_write_i) |-> acc_err_o);

  // R11
  err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_err_o |-> (rd_data_o == '0));

endmodule

// File: tb/sim_irq_mask_ctrl.sv
module sim_irq_mask_ctrl;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [63:0] rd_data;
  logic        acc_err;
  logic [7:0]  set_vec = '0, clr_vec = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_pend = '0, m_en = '0, m_aux = '0;
  logic       m_irq = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_mask_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_wide_i(acc_wide),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
    .rd_data_o(rd_data), .acc_err_o(acc_err),
    .set_vec_i(set_vec), .clr_vec_i(clr_vec), .irq_o(irq)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic ref_err(logic v, logic w, logic wd, logic [2:0] a);
    if (!v) return 1'b0;
    if (wd) return w || (a != 3'd1);
    return (a > 3'd4) || (w && a == 3'd1) || (!w && a == 3'd2);
  endfunction

  function automatic logic [63:0] ref_rd(logic v, logic w, logic wd, logic [2:0] a);
    logic [63:0] r = '0;
    if (!v || w || ref_err(v, w, wd, a)) return r;
    case (a)
      3'd0: r[7:0] = ~m_en;
      3'd1: r[7:0] = m_pend;
      3'd3: r[7:0] = m_aux;
      default: r = '0;
    endcase
    return r;
  endfunction

  // one cycle: drive, compare before the edge, advance the model at the edge
  task automatic step(string tag, logic v, logic w, logic wd, logic [2:0] a,
                      logic [7:0] d, logic [7:0] s, logic [7:0] c);
    logic [7:0] ackm;
    int n;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_wide = wd; acc_addr = a; acc_wdata = d;
    set_vec = s; clr_vec = c;
    #1;
    check(tag, "irq", {63'd0, irq}, {63'd0, m_irq});
    check(tag, "err", {63'd0, acc_err}, {63'd0, ref_err(v, w, wd, a)});
    check(tag, "rdata", rd_data, ref_rd(v, w, wd, a));
    @(posedge clk);
    ackm = '0;
    if (v && w && !ref_err(v, w, wd, a)) begin
      if (a == 3'd0) m_en = ~d;
      if (a == 3'd3) m_aux = d;
      if (a == 3'd2) begin
        n = int'(d[3:0]);
        if (n < 8) ackm[n] = 1'b1;
      end
    end
    m_pend = ((m_pend | s) & ~c) & ~ackm;
    m_irq  = |(m_pend & m_en);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    acc_valid = 1'b1; acc_addr = 3'd0;
    #1;
    check("R1", "irq in reset", {63'd0, irq}, 64'd0);
    check("R1", "mask read in reset", rd_data, 64'hFF);
    acc_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step("R1", 1, 0, 0, 3'd0, 8'h00, 8'h00, 8'h00);
    step("R1", 1, 0, 0, 3'd3, 8'h00, 8'h00, 8'h00);
    step("R7", 1, 0, 0, 3'd1, 8'h00, 8'h00, 8'h00);
    // R4: set lines 0 and 2, still all disabled
    step("R4", 0, 0, 0, 3'd0, 8'h00, 8'h05, 8'h00);
    step("R7", 1, 0, 0, 3'd1, 8'h00, 8'h00, 8'h00);
    // R2: enable line 0 via inverted write
    step("R2", 1, 1, 0, 3'd0, 8'hFE, 8'h00, 8'h00);
    step("R2", 1, 0, 0, 3'd0, 8'h00, 8'h00, 8'h00);
    // R3: disable all, request drops
    step("R3", 1, 1, 0, 3'd0, 8'hFF, 8'h00, 8'h00);
    step("R3", 1, 1, 0, 3'd0, 8'hFA, 8'h00, 8'h00);
    step("R3", 0, 0, 0, 3'd0, 8'h00, 8'h00, 8'h00);
    // R6: ack line 0 with upper nibble set, then out-of-range numbers
    step("R6", 1, 1, 0, 3'd2, 8'h10, 8'h00, 8'h00);
    step("R6", 1, 1, 0, 3'd2, 8'h09, 8'h00, 8'h00);
    step("R6", 1, 1, 0, 3'd2, 8'h0F, 8'h00, 8'h00);
    step("R6", 1, 0, 0, 3'd1, 8'h00, 8'h00, 8'h00);
    // R5: withdraw line 2, then set and withdraw the same line together
    step("R5", 0, 0, 0, 3'd0, 8'h00, 8'h00, 8'h04);
    step("R5", 0, 0, 0, 3'd0, 8'h00, 8'h30, 8'h10);
    step("R5", 1, 0, 0, 3'd1, 8'h00, 8'h00, 8'h00);
    // R8: secondary mask all ones, line 5 pending but not enabled
    step("R8", 1, 1, 0, 3'd3, 8'hFF, 8'h00, 8'h00);
    step("R8", 1, 0, 0, 3'd3, 8'h00, 8'h00, 8'h00);
    step("R8", 0, 0, 0, 3'd0, 8'h00, 8'h00, 8'h00);
    // R9
    step("R9", 1, 0, 0, 3'd4, 8'h00, 8'h00, 8'h00);
    step("R9", 1, 1, 0, 3'd4, 8'hFF, 8'h00, 8'h00);
    step("R9", 1, 0, 0, 3'd3, 8'h00, 8'h00, 8'h00);
    // R10
    step("R10", 1, 0, 1, 3'd1, 8'h00, 8'h80, 8'h00);
    step("R10", 1, 0, 1, 3'd1, 8'h00, 8'h00, 8'h00);
    // R11: illegal accesses carrying state-changing data
    step("R11", 1, 1, 1, 3'd0, 8'h00, 8'h00, 8'h00);
    step("R11", 1, 0, 1, 3'd0, 8'h00, 8'h00, 8'h00);
    step("R11", 1, 1, 1, 3'd1, 8'h00, 8'h00, 8'h00);
    step("R11", 1, 1, 0, 3'd1, 8'h00, 8'h00, 8'h00);
    step("R11", 1, 0, 0, 3'd2, 8'h00, 8'h00, 8'h00);
    step("R11", 1, 1, 0, 3'd5, 8'h00, 8'h00, 8'h00);
    step("R11", 1, 0, 0, 3'd7, 8'h00, 8'h00, 8'h00);
    step("R11", 1, 0, 0, 3'd0, 8'h00, 8'h00, 8'h00);
    // R6: ack wins over a set of the same line
    step("R6", 1, 1, 0, 3'd0, 8'h00, 8'h00, 8'h00);
    step("R6", 1, 1, 0, 3'd2, 8'h05, 8'h20, 8'h00);
    step("R6", 1, 0, 0, 3'd1, 8'h00, 8'h00, 8'h00);
    // mixed traffic against the model (R3)
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      step("R3", r[0], r[1], (r[4:2] == 3'd0), r[7:5], r[15:8],
           (r[18:16] == 3'd0) ? r[23:16] : 8'h00,
           (r[26:24] == 3'd0) ? r[31:24] : 8'h00);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule